// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block shifts or rotates a 32-bit data word by an amount taken from a general-purpose register and produces both the shifted word and the carry flag that the operation leaves behind. Four operations are offered: logical left, logical right, arithmetic right and rotate right. The amount comes from a full register, but only its low byte counts. Amounts from 32 to 255 are therefore legal, and each one has a defined result and carry.

Each cycle the block samples the data word, the amount register, the operation select and the current carry flag. On the next clock edge it registers the result and the next carry. An amount of zero passes both the word and the incoming carry through untouched. Rotation works modulo the word width. A nonzero amount that is a whole multiple of the width is still handled as a rotation, so it updates the carry even though the word comes out unchanged.

Top module: `reg_amount_shifter`

## Requirements
- R1: The operation select is encoded as 0 for logical left, 1 for logical right, 2 for arithmetic right and 3 for rotate right. Only bits [7:0] of `amount` set the shift amount, and bits [31:8] have no effect. The result and carry for the inputs sampled at one rising edge appear at the outputs after that edge.
- R2: When the low byte of the amount is zero, the result equals the data word and the next carry equals `carry_in`, for every operation.
- R3: A logical left shift by n in 1..31 gives data << n, and the carry takes input bit 32-n.
- R4: A logical left shift by exactly 32 gives zero, and the carry takes input bit 0.
- R5: A logical left or logical right shift by 33..255 gives zero with the carry cleared.
- R6: A logical right shift by n in 1..31 gives data >> n with zero fill, and the carry takes input bit n-1.
- R7: A logical right shift by exactly 32 gives zero, and the carry takes input bit 31.
- R8: An arithmetic right shift by n in 1..31 fills with the sign bit, and the carry takes input bit n-1.
- R9: An arithmetic right shift by 32..255 sets every result bit to input bit 31, and the carry also equals input bit 31.
- R10: A rotate right whose amount modulo 32 is a nonzero k gives the word rotated right by k, and the carry takes input bit k-1.
- R11: A rotate right whose amount is nonzero with amount modulo 32 equal to zero returns the data unchanged, and the carry takes input bit 31.
- R12: While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| op | input | 2 | Operation select (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| data | input | 32 | Word to be shifted |
| amount | input | 32 | Shift amount register; only bits [7:0] are used |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered shifted word |
| carry_out | output | 1 | Registered next carry flag |

## Verification
The bench sweeps every amount from 0 to 255 under each operation, using several data patterns and random upper amount bits. A reference model shifts one bit position per step, so it reaches the correct answer by a different path from the design. The seams get particular attention:
- Amount 32 for logical shifts: a design that handled it like 33 would clear the carry instead of taking bit 0 or bit 31.
- Amounts of 64, 96 and up for rotation: a design that reduced these to zero would keep the old carry instead of loading bit 31.
- Amounts above 31 for arithmetic shifts: a design that wrapped the amount would return a partly shifted word instead of sign fill.
- Upper amount bits: a design that read beyond the low byte would treat 256 as a large shift instead of as zero.

// File: rtl/reg_amount_shifter.sv
module reg_amount_shifter #(
  parameter int WIDTH    = 32,
  parameter int REG_W    = 32,
  parameter int AMT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] data,
  input  logic [REG_W-1:0] amount,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int LOG2 = $clog2(WIDTH);
  localparam logic [AMT_BITS-1:0] FULL = AMT_BITS'(WIDTH);
  localparam logic [1:0] OP_LSL = 2'd0, OP_LSR = 2'd1, OP_ASR = 2'd2;

  logic [AMT_BITS-1:0] amt;
  logic [LOG2-1:0]     rot, dn_idx, up_idx;
  logic                is_zero, below, exact;
  logic [WIDTH-1:0]    nxt_res;
  logic                nxt_c;

  assign amt     = amount[AMT_BITS-1:0];
  assign rot     = amt[LOG2-1:0];
  assign dn_idx  = rot - LOG2'(1);
  assign up_idx  = LOG2'(WIDTH - int'(rot));
  assign is_zero = (amt == '0);
  assign below   = (amt < FULL);
  assign exact   = (amt == FULL);

  always_comb begin
    nxt_res = data;
    nxt_c   = carry_in;
    if (!is_zero) begin
      case (op)
        OP_LSL: begin
          if (below) begin
            nxt_res = data << rot;
            nxt_c   = data[up_idx];
          end else begin
            nxt_res = '0;
            nxt_c   = exact & data[0];
          end
        end
        OP_LSR: begin
          if (below) begin
            nxt_res = data >> rot;
            nxt_c   = data[dn_idx];
          end else begin
            nxt_res = '0;
            nxt_c   = exact & data[WIDTH-1];
          end
        end
        OP_ASR: begin
          if (below) begin
            nxt_res = $signed(data) >>> rot;
            nxt_c   = data[dn_idx];
          end else begin
            nxt_res = {WIDTH{data[WIDTH-1]}};
            nxt_c   = data[WIDTH-1];
          end
        end
        default: begin
          if (rot == '0) begin
            nxt_c = data[WIDTH-1];
          end else begin
            nxt_res = (data >> rot) | (data << up_idx);
            nxt_c   = data[dn_idx];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_c;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_reset_clear_R12: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !carry_out));

  assert_high_bits_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(op) && $stable(data) && $stable(carry_in) &&
     $stable(amount[AMT_BITS-1:0]) && !$stable(amount[REG_W-1:AMT_BITS]))
    |=> ($stable(result) && $stable(carry_out)));

  assert_zero_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (amount[AMT_BITS-1:0] == '0)
    |=> (result == $past(data) && carry_out == $past(carry_in)));

  assert_lsl_far_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LSL && amount[AMT_BITS-1:0] > FULL)
    |=> (result == '0 && !carry_out));

  assert_asr_sign_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ASR && amount[AMT_BITS-1:0] >= FULL)
    |=> (result == {WIDTH{$past(data[WIDTH-1])}} && carry_out == $past(data[WIDTH-1])));

  assert_ror_whole_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3 && amount[AMT_BITS-1:0] != '0 && amount[LOG2-1:0] == '0)
    |=> (result == $past(data) && carry_out == $past(data[WIDTH-1])));
endmodule

// File: tb/tb_reg_amount_shifter.sv
module tb_reg_amount_shifter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op;
  logic [31:0] data, amount, result;
  logic        carry_in, carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  reg_amount_shifter dut (
    .clk(clk), .rst_n(rst_n), .op(op), .data(data), .amount(amount),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  task automatic model(input logic [1:0] o, input logic [31:0] d, input logic [31:0] a,
                       input bit ci, output logic [31:0] r, output bit co);
    int n = int'(a[7:0]);
    r = d;
    co = ci;
    for (int i = 0; i < n; i++) begin
      case (o)
        2'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
        default: begin co = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endtask

  function automatic string req_of(input logic [1:0] o, input int n);
    if (n == 0) return "R2";
    case (o)
      2'd0: return (n < 32) ? "R3" : (n == 32) ? "R4" : "R5";
      2'd1: return (n < 32) ? "R6" : (n == 32) ? "R7" : "R5";
      2'd2: return (n < 32) ? "R8" : "R9";
      default: return (n % 32 != 0) ? "R10" : "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] er, input bit ec);
    checks++;
    if (result !== er || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: result=%h carry=%0b expected result=%h carry=%0b",
               req, result, carry_out, er, ec);
    end
  endtask

  initial begin
    logic [31:0] exp_r;
    bit          exp_c;
    string       exp_q;
    bit          pending;
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h5A3C_F069;
    pending = 1'b0;
    rst_n = 1'b0;
    op = 2'd3; data = 32'hFFFF_FFFF; amount = 32'd5; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", 32'h0, 1'b0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int n = 0; n < 256; n++) begin
          @(negedge clk);
          if (pending) check(exp_q, exp_r, exp_c);
          op       = 2'(o);
          data     = pats[p] ^ (n[0] ? 32'h0 : $urandom());
          amount   = {$urandom() & 32'hFFFF_FF00} | 32'(n);
          carry_in = 1'($urandom());
          model(op, data, amount, carry_in, exp_r, exp_c);
          exp_q = req_of(op, n);
          if (amount[31:8] != 0 && n == 0) exp_q = "R1/R2";
          pending = 1'b1;
        end
      end
    end
    // R1: upper amount bits set with low byte 0x21 behaves as a shift by 33
    @(negedge clk);
    check(exp_q, exp_r, exp_c);
    op = 2'd0; data = 32'hFFFF_FFFF; amount = 32'hFFFF_FF21; carry_in = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);
    op = 2'd1; data = 32'h8000_0000; amount = 32'h0000_0120; carry_in = 1'b0;
    @(negedge clk);
    check("R1", 32'h0, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule